// File: doc/BRIEF.md
# Pad Function Router

This block sits between a set of on-chip signal sources and a smaller set of physical pads. Every pad has a two-bit select field that picks one of four owners for that pad. Owner 0 is the plain general-purpose I/O path. Owners 1 to 3 are peripheral functions, and which function sits in which owner position depends on the pad. Each pad is modelled as three wires: the level read from the pad, the level driven onto it, and an output enable. Input enable is simply the inverse of the output enable.

On the output side, one select value steers both the driven level and the output enable of a pad. A bidirectional function therefore controls the direction of every pad it owns. On the input side, each function input gathers every pad whose select points at that function. It passes on the level of exactly one of those pads, chosen by fixed priority, so two pads can never fight over one input.

The select fields are held in registers behind a small word-addressed write and read port. Everything after those registers is combinational.

Top module: `iomux`

## Requirements
- R1: After reset, every select field is 0, so every pad follows its general-purpose output level and output enable.
- R2: A pad whose select is 0 drives `pad_out[p] = gpio_out[p]` and `pad_oe[p] = gpio_oe[p]`.
- R3: A pad p whose select is s (1 to 3) drives both `pad_out[p]` and `pad_oe[p]` from function `(p + s - 1) mod NFUNC`, using the same select for both. When no source enables its output, no pad is enabled.
- R4: One function may own several pads at once. Each of those pads carries that function's output level and enable.
- R5: Function input f takes the level of the lowest-indexed pad whose select maps to f under the R3 rule.
- R6: A function input with no selecting pad reads its idle level, bit f of parameter `FN_IDLE` (default 6'b100101).
- R7: `gpio_in[p]` always equals `pad_in[p]`, whatever the select value.
- R8: Register word a holds pad `FPW*a + k` in bits [2k+1:2k], where FPW = DW/2. A write with `wr_en` high updates the fields on the next rising clock edge. `rd_data` shows the word at `rd_addr` combinationally.
- R9: Field positions with no pad read 0. A write to an address with no pads changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address for writes |
| wr_data | input | DW | Write data, two bits per pad |
| rd_addr | input | AW | Register word address for reads |
| rd_data | output | DW | Read data for `rd_addr` |
| gpio_out | input | NPADS | General-purpose output levels |
| gpio_oe | input | NPADS | General-purpose output enables |
| gpio_in | output | NPADS | General-purpose input levels |
| fn_out | input | NFUNC | Function output levels |
| fn_oe | input | NFUNC | Function output enables |
| fn_in | output | NFUNC | Function input levels |
| pad_in | input | NPADS | Level seen on each pad |
| pad_out | output | NPADS | Level driven onto each pad |
| pad_oe | output | NPADS | Output enable of each pad |

## Verification
The bench sets up configurations where a single function owns many pads. It then drives those pads with conflicting levels. A priority chain that scanned in the wrong direction would deliver the highest pad's level instead of the lowest. A design that picked one owner for the level and another for the enable would show an enable that does not match the owner of the driven level. The bench also writes to the partly filled upper word and to addresses with no pads behind them. A slip in the field decoding would either corrupt neighbouring pads or make phantom bits read back as 1. Finally, all selects are cleared to confirm that every function input falls back to its own idle level and not to a common constant.

// File: rtl/iomux.sv
module iomux #(
  parameter int NPADS = 20,
  parameter int NFUNC = 6,
  parameter int DW = 32,
  parameter int AW = 2,
  parameter logic [NFUNC-1:0] FN_IDLE = 6'b100101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [NPADS-1:0] gpio_out,
  input  logic [NPADS-1:0] gpio_oe,
  output logic [NPADS-1:0] gpio_in,
  input  logic [NFUNC-1:0] fn_out,
  input  logic [NFUNC-1:0] fn_oe,
  output logic [NFUNC-1:0] fn_in,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe
);
  localparam int FPW = DW / 2;

  logic [1:0] sel_q [NPADS];
  logic [NFUNC-1:0][NPADS-1:0] hit;

  assign gpio_in = pad_in;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    localparam int WRD = p / FPW;
    localparam int BIT = 2 * (p % FPW);
    localparam int F1 = p % NFUNC;
    localparam int F2 = (p + 1) % NFUNC;
    localparam int F3 = (p + 2) % NFUNC;

    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[p] <= 2'd0;
      else if (wr_en && wr_addr == AW'(WRD))
        sel_q[p] <= wr_data[BIT +: 2];
    end

    always_comb begin
      unique case (sel_q[p])
        2'd0: begin pad_out[p] = gpio_out[p]; pad_oe[p] = gpio_oe[p]; end
        2'd1: begin pad_out[p] = fn_out[F1];  pad_oe[p] = fn_oe[F1];  end
        2'd2: begin pad_out[p] = fn_out[F2];  pad_oe[p] = fn_oe[F2];  end
        default: begin pad_out[p] = fn_out[F3]; pad_oe[p] = fn_oe[F3]; end
      endcase
    end

    for (genvar f = 0; f < NFUNC; f++) begin : g_cmp
      assign hit[f][p] = (sel_q[p] == 2'd1 && F1 == f) ||
                         (sel_q[p] == 2'd2 && F2 == f) ||
                         (sel_q[p] == 2'd3 && F3 == f);
    end
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn
    logic lvl;
    always_comb begin
      lvl = FN_IDLE[f];
      for (int p = NPADS - 1; p >= 0; p--)
        if (hit[f][p]) lvl = pad_in[p];
    end
    assign fn_in[f] = lvl;
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPADS; p++)
      if (rd_addr == AW'(p / FPW))
        rd_data[2 * (p % FPW) +: 2] = sel_q[p];
  end
endmodule

// File: rtl/iomux_chk.sv
module iomux_chk #(
  parameter int NPADS = 20,
  parameter int NFUNC = 6,
  parameter int DW = 32,
  parameter int AW = 2,
  parameter logic [NFUNC-1:0] FN_IDLE = 6'b100101
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic [NPADS-1:0] gpio_out,
  input logic [NPADS-1:0] gpio_oe,
  input logic [NFUNC-1:0] fn_oe,
  input logic [NFUNC-1:0] fn_in,
  input logic [NPADS-1:0] pad_in,
  input logic [NPADS-1:0] pad_out,
  input logic [NPADS-1:0] pad_oe
);
  function automatic logic [DW-1:0] word0_mask();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < DW; i++) if (i / 2 < NPADS) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [DW-1:0] MASK0 = word0_mask();

  p_reset_gpio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_out == gpio_out && pad_oe == gpio_oe));

  p_oe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_oe == '0 && fn_oe == '0) |-> pad_oe == '0);

  p_low_pads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_in == '0) |-> ((fn_in & ~FN_IDLE) == '0));

  p_high_pads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&pad_in) |-> ((~fn_in & FN_IDLE) == '0));

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=>
      (rd_addr != '0 || ((rd_data ^ $past(wr_data)) & MASK0) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_addr != $past(rd_addr) || $stable(rd_data)));
endmodule

bind iomux iomux_chk #(.NPADS(NPADS), .NFUNC(NFUNC), .DW(DW), .AW(AW), .FN_IDLE(FN_IDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
  .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/iomux_tb.sv
module iomux_tb;
  localparam int NPADS = 20;
  localparam int NFUNC = 6;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [NFUNC-1:0] IDLE = 6'b100101;
  localparam int FPW = DW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NPADS-1:0] gpio_out = '0, gpio_oe = '0, gpio_in, pad_in = '0, pad_out, pad_oe;
  logic [NFUNC-1:0] fn_out = '0, fn_oe = '0, fn_in;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_sel [NPADS];

  always #4 clk = ~clk;

  iomux u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int owner(int p, int s);
    return (p + s - 1) % NFUNC;
  endfunction

  function automatic logic [NPADS-1:0] e_out(bit oe);
    logic [NPADS-1:0] r;
    for (int p = 0; p < NPADS; p++) begin
      if (m_sel[p] == 0) r[p] = oe ? gpio_oe[p] : gpio_out[p];
      else r[p] = oe ? fn_oe[owner(p, m_sel[p])] : fn_out[owner(p, m_sel[p])];
    end
    return r;
  endfunction

  function automatic logic [NFUNC-1:0] e_fn_in();
    logic [NFUNC-1:0] r;
    for (int f = 0; f < NFUNC; f++) begin
      bit found = 0;
      r[f] = IDLE[f];
      for (int p = 0; p < NPADS; p++)
        if (!found && m_sel[p] != 0 && owner(p, m_sel[p]) == f) begin
          found = 1;
          r[f] = pad_in[p];
        end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] e_word(int a);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < FPW; k++)
      if (a * FPW + k < NPADS) r[2*k +: 2] = 2'(m_sel[a * FPW + k]);
    return r;
  endfunction

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int p = 0; p < NPADS; p++)
      if (p / FPW == a) m_sel[p] = int'(d[2*(p%FPW) +: 2]);
  endtask

  task automatic check_pads(string tag);
    #1;
    chk({tag, " R2/R3 pad_out"}, 64'(pad_out), 64'(e_out(0)));
    chk({tag, " R3 pad_oe"}, 64'(pad_oe), 64'(e_out(1)));
    chk({tag, " R5/R6 fn_in"}, 64'(fn_in), 64'(e_fn_in()));
    chk({tag, " R7 gpio_in"}, 64'(gpio_in), 64'(pad_in));
  endtask

  task automatic check_regs(string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      #1 chk({tag, " R8/R9 readback"}, 64'(rd_data), 64'(e_word(a)));
    end
  endtask

  task automatic rand_in();
    gpio_out = NPADS'($urandom); gpio_oe = NPADS'($urandom);
    fn_out = NFUNC'($urandom); fn_oe = NFUNC'($urandom);
    pad_in = NPADS'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9127));
    for (int p = 0; p < NPADS; p++) m_sel[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rand_in();
    check_pads("R1 reset");
    check_regs("R1 reset");

    // R4: slot 1 everywhere, function p%6; pads 0,6,12,18 share function 0
    wr(0, 32'h5555_5555);
    wr(1, 32'h0000_0055);
    fn_out = 6'b000001; fn_oe = 6'b000001; gpio_out = '0; gpio_oe = '0;
    #1 chk("R4 many pads one function", 64'(pad_out & pad_oe), 64'(20'h41041));
    check_pads("R4");
    // R5: pad 0 low, pad 6 high -> lowest wins
    pad_in = 20'h00040;
    #1 chk("R5 lowest pad wins", 64'(fn_in[0]), 64'(1'b0));
    pad_in = 20'hFFFFE;
    #1 chk("R5 lowest pad wins high", 64'(fn_in[0]), 64'(1'b0));
    pad_in = 20'h00001;
    #1 chk("R5 pad0 high", 64'(fn_in[0]), 64'(1'b1));

    // R9: write ones to unused upper fields and to pad-less addresses
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hAAAA_AAAA);
    check_regs("R9 unused");
    check_pads("R9");

    // R6: all selects cleared
    wr(0, '0); wr(1, '0);
    pad_in = '1;
    #1 chk("R6 idle all high pads", 64'(fn_in), 64'(IDLE));
    pad_in = '0;
    #1 chk("R6 idle all low pads", 64'(fn_in), 64'(IDLE));

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) wr($urandom_range(0, 3), $urandom);
      else @(negedge clk);
      rand_in();
      check_pads("random");
      if (i % 50 == 0) check_regs("random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule